// File: doc/BRIEF.md
# Single-Wire Slave Bit-Slot Engine

This block is the slave-side physical layer of a single-wire, open-drain serial bus. A master starts every transaction by pulling the shared line low. A low period much longer than any data slot is a bus reset, and the slave answers it with a presence pulse. Each shorter low period that the master starts is one bit time slot. The slave decodes it as a received bit, or it serves it as a transmitted bit by holding the line low to send a zero. The block never drives the line high. It only asserts a pull-down enable, so the bus forms a wired-AND with the master and any other slaves.

The line passes through a two-flop synchronizer. Every duration is counted in microsecond ticks. A clock divider produces the ticks and restarts at each state change, so every window is measured from the edge that opened it. The upper layer sees three interfaces: a received-bit strobe, a valid/ready transmit channel, and a one-cycle bus-reset indication. The received-bit strobe has no back-pressure, because a bus bit cannot be held off, so the upper layer must take `rx_valid` in the cycle it is high. On the transmit channel the upper layer holds `tx_valid` and `tx_bit` steady before the master opens a slot. `tx_ready` pulses for one cycle when that slot begins, and the bit is consumed in that cycle. If `tx_valid` is still low when the slot opens, the slot is decoded as a write from the master.

Top module: `wire_slot_engine`

## Requirements
- R1: After `rst`, the pull-down enable is low, and no `rx_valid`, `tx_ready` or `bus_reset` pulse appears while the line stays idle high.
- R2: When the synchronized line has been low for RST_LOW_US microseconds, not counting time the block drives it low itself, `bus_reset` pulses for exactly one cycle. Any slot in progress is abandoned and the pull-down is released.
- R3: After a bus reset the line goes high again. The block then waits PD_WAIT_US microseconds and drives the line low for PD_LOW_US microseconds as its presence pulse.
- R4: A slot that starts with no transmit pending is a write slot. SAMPLE_US microseconds after the falling edge, the block emits one `rx_valid` strobe. `rx_bit` is 1 if the line is high at that point and 0 if it is low.
- R5: A slot is a read slot when `tx_valid` is high at its falling edge. `tx_ready` pulses at that edge. For `tx_bit`=0 the line is held low from the edge until RD_HOLD_US microseconds later. For `tx_bit`=1 the line is never driven.
- R6: If `tx_valid` rises after a slot's falling edge, that slot stays a write slot. It gives no `tx_ready`, the line is not driven, and it is decoded per R4.
- R7: A read slot produces no `rx_valid`, and no slot produces more than one.
- R8: The block's own presence pulse, although it lasts as long as a reset, never causes a `bus_reset`.
- R9: A write-0 low time that stays below RST_LOW_US, for example 110 us, is decoded as a 0 and not as a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Asynchronous bus line level |
| bus_pull_low | output | 1 | Open-drain pull-down enable (1 = pull line low) |
| rx_valid | output | 1 | One-cycle strobe: a write-slot bit was received |
| rx_bit | output | 1 | Received bit value, valid with `rx_valid` |
| tx_valid | input | 1 | A transmit bit is pending for the next slot |
| tx_bit | input | 1 | Bit to send in the next read slot |
| tx_ready | output | 1 | Pending transmit bit consumed by a starting slot |
| bus_reset | output | 1 | One-cycle strobe: bus reset detected |

## Verification
The bench goes after four corner cases, each with the failure it would expose:
- A reset that arrives in the middle of a read-0 slot. A design that does not abort would keep pulling the line low or miss the reset strobe.
- The block's own 120 us presence pulse. A low-time counter that also counts self-driven time would report a second, phantom reset.
- A 110 us write-0. This is close to the reset threshold, so a threshold set too short would turn it into a reset.
- A transmit request raised after a slot has started. A design that checks `tx_valid` late would drive the line in the middle of the master's write slot and corrupt the received bit.

// File: rtl/wse_pkg.sv
package wse_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSLOT,
    ST_RSLOT,
    ST_WAITHI,
    ST_RSTLOW,
    ST_PDWAIT,
    ST_PDDRV
  } wse_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wse_us_tick.sv
module wse_us_tick #(
  parameter int CLK_DIV = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] cnt;

  assign tick = (cnt == DW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> !tick || (CLK_DIV == 1)) else $error("tick repeated"); // R3
endmodule

// File: rtl/wse_line_sync.sv
module wse_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic fell
);
  logic ff1, ff2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ff1  <= 1'b1;
      ff2  <= 1'b1;
      prev <= 1'b1;
    end else begin
      ff1  <= line_in;
      ff2  <= ff1;
      prev <= ff2;
    end
  end

  assign line_s = ff2;
  assign fell   = prev & ~ff2;

  AST_FELL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fell |=> !fell) else $error("double fall"); // R4
endmodule

// File: rtl/wse_low_watch.sv
module wse_low_watch #(
  parameter int LIMIT_CYC = 24000
) (
  input  logic clk,
  input  logic rst,
  input  logic line_s,
  input  logic own_drive,
  output logic hit
);
  localparam int LW = $clog2(LIMIT_CYC + 1);

  logic [LW-1:0] cnt;
  logic          counting;

  assign counting = ~line_s & ~own_drive;
  assign hit      = counting && (cnt == LW'(LIMIT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !counting)              cnt <= '0;
    else if (cnt != LW'(LIMIT_CYC))    cnt <= cnt + 1'b1;
  end

  AST_HIT_NOT_SELF: assert property (@(posedge clk) disable iff (rst)
    own_drive |-> !hit) else $error("own drive counted"); // R8
endmodule

// File: rtl/wire_slot_engine.sv
module wire_slot_engine
  import wse_pkg::*;
#(
  parameter int CLK_DIV    = 200,
  parameter int SAMPLE_US  = 30,
  parameter int RD_HOLD_US = 30,
  parameter int PD_WAIT_US = 30,
  parameter int PD_LOW_US  = 120,
  parameter int RST_LOW_US = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_in,
  output logic bus_pull_low,
  output logic rx_valid,
  output logic rx_bit,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_ready,
  output logic bus_reset
);
  localparam int MAX_US  = max2(max2(SAMPLE_US, RD_HOLD_US), max2(PD_WAIT_US, PD_LOW_US));
  localparam int TW      = $clog2(MAX_US + 1);
  localparam int RST_CYC = RST_LOW_US * CLK_DIV;

  wse_state_t    state, state_n;
  logic [TW-1:0] us_cnt;
  logic          bit_q, bit_n;
  logic          rxv_n, rxb_n;
  logic          line_s, fell, tick, low_hit, restart;

  wse_line_sync u_sync (
    .clk(clk), .rst(rst), .line_in(bus_in), .line_s(line_s), .fell(fell)
  );

  wse_us_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .clr(restart), .tick(tick)
  );

  wse_low_watch #(.LIMIT_CYC(RST_CYC)) u_low (
    .clk(clk), .rst(rst), .line_s(line_s), .own_drive(bus_pull_low), .hit(low_hit)
  );

  assign restart  = (state_n != state);
  assign tx_ready = (state == ST_IDLE) && fell && tx_valid;

  always_comb begin
    state_n = state;
    bit_n   = bit_q;
    rxv_n   = 1'b0;
    rxb_n   = rx_bit;
    unique case (state)
      ST_IDLE: if (fell) begin
        if (tx_valid) begin
          state_n = ST_RSLOT;
          bit_n   = tx_bit;
        end else begin
          state_n = ST_WSLOT;
        end
      end
      ST_WSLOT: if (tick && us_cnt == TW'(SAMPLE_US - 1)) begin
        rxv_n   = 1'b1;
        rxb_n   = line_s;
        state_n = ST_WAITHI;
      end
      ST_RSLOT:  if (tick && us_cnt == TW'(RD_HOLD_US - 1)) state_n = ST_WAITHI;
      ST_WAITHI: if (line_s) state_n = ST_IDLE;
      ST_RSTLOW: if (line_s) state_n = ST_PDWAIT;
      ST_PDWAIT: if (tick && us_cnt == TW'(PD_WAIT_US - 1)) state_n = ST_PDDRV;
      ST_PDDRV:  if (tick && us_cnt == TW'(PD_LOW_US - 1)) state_n = ST_WAITHI;
      default:   state_n = ST_IDLE;
    endcase
    if (low_hit) begin
      state_n = ST_RSTLOW;
      rxv_n   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      us_cnt       <= '0;
      bit_q        <= 1'b1;
      rx_valid     <= 1'b0;
      rx_bit       <= 1'b0;
      bus_reset    <= 1'b0;
      bus_pull_low <= 1'b0;
    end else begin
      state        <= state_n;
      bit_q        <= bit_n;
      rx_valid     <= rxv_n;
      rx_bit       <= rxb_n;
      bus_reset    <= low_hit;
      bus_pull_low <= (state_n == ST_PDDRV) || (state_n == ST_RSLOT && !bit_n);
      if (restart)   us_cnt <= '0;
      else if (tick) us_cnt <= us_cnt + 1'b1;
    end
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> !bus_reset) else $error("long reset strobe"); // R2
  AST_RST_RELEASES: assert property (@(posedge clk) disable iff (rst)
    bus_reset |-> !bus_pull_low && state == ST_RSTLOW) else $error("drive kept on reset"); // R2
  AST_DRIVE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    bus_pull_low |-> (state == ST_PDDRV) || (state == ST_RSLOT && !bit_q)) else $error("illegal drive"); // R5
  AST_RX_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid) else $error("double rx strobe"); // R7
  AST_RX_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(state) == ST_WSLOT) else $error("rx outside write slot"); // R7
  AST_TXRDY_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    tx_ready |=> state == ST_RSLOT || state == ST_RSTLOW) else $error("ready without read slot"); // R5
  AST_NO_RESET_IN_PD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PDDRV) |-> !low_hit) else $error("presence seen as reset"); // R8
endmodule

// File: tb/test_wire_slot_engine.sv
module test_wire_slot_engine;
  localparam int DIV = 4;

  // vector: {is_read, value, expected}
  localparam logic [2:0] VEC [10] = '{
    3'b011, 3'b000, 3'b111, 3'b100, 3'b000,
    3'b011, 3'b100, 3'b111, 3'b011, 3'b100
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_low = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_bit = 1'b1;
  logic bus_pull_low, rx_valid, rx_bit, tx_ready, bus_reset;
  logic line;

  int n_chk = 0, n_fail = 0;
  int rx_cnt = 0, rst_cnt = 0, hs_cnt = 0;
  logic rx_last = 1'b0;

  always #2.5 clk = ~clk;

  assign line = ~(master_low | bus_pull_low);

  wire_slot_engine #(.CLK_DIV(DIV)) i_wire_slot_engine (
    .clk(clk), .rst(rst), .bus_in(line), .bus_pull_low(bus_pull_low),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_valid(tx_valid), .tx_bit(tx_bit),
    .tx_ready(tx_ready), .bus_reset(bus_reset)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin rx_cnt++; rx_last = rx_bit; end
      if (bus_reset) rst_cnt++;
      if (tx_valid && tx_ready) hs_cnt++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wus(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic write_slot(input logic b, input int low_us);
    master_low = 1'b1;
    wus(b ? 5 : low_us);
    master_low = 1'b0;
    wus(b ? 80 : 15);
  endtask

  // bus reset plus presence-pulse timing checks (R2, R3, R8)
  task automatic bus_reset_seq(input int low_us);
    int r0;
    r0 = rst_cnt;
    master_low = 1'b1;
    wus(low_us);
    chk("R2 reset strobe count", rst_cnt - r0, 1);
    chk("R2 pull released during reset", int'(bus_pull_low), 0);
    master_low = 1'b0;
    wus(20);  chk("R3 no drive before wait", int'(line), 1);
    wus(25);  chk("R3 presence low at 45us", int'(line), 0);
    wus(95);  chk("R3 presence low at 140us", int'(line), 0);
    wus(20);  chk("R3 presence released at 160us", int'(line), 1);
    wus(10);  chk("R8 presence not a reset", rst_cnt - r0, 1);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    wus(50);
    chk("R1 idle pull", int'(bus_pull_low), 0);
    chk("R1 no rx", rx_cnt, 0);
    chk("R1 no reset", rst_cnt, 0);
    chk("R1 no handshake", hs_cnt, 0);

    bus_reset_seq(500);

    for (int i = 0; i < 10; i++) begin
      int rx0, hs0;
      logic seen, late;
      rx0 = rx_cnt; hs0 = hs_cnt;
      if (VEC[i][2]) begin
        tx_valid = 1'b1; tx_bit = VEC[i][1];
        wus(1);
        master_low = 1'b1; wus(2); master_low = 1'b0;
        wus(13); seen = line;
        wus(5);  tx_valid = 1'b0;
        wus(20); late = line;
        wus(45);
        chk("R5 read bit at master sample", int'(seen), int'(VEC[i][0]));
        chk("R5 line released before slot end", int'(late), 1);
        chk("R5 handshake once", hs_cnt - hs0, 1);
        chk("R7 no rx in read slot", rx_cnt - rx0, 0);
      end else begin
        write_slot(VEC[i][1], 70);
        chk("R4 one rx per write slot", rx_cnt - rx0, 1);
        chk("R4 rx bit", int'(rx_last), int'(VEC[i][0]));
      end
    end

    begin : late_tx
      int rx0, hs0;
      logic mid;
      rx0 = rx_cnt; hs0 = hs_cnt;
      master_low = 1'b1; wus(3);
      tx_valid = 1'b1; tx_bit = 1'b0;
      wus(2); master_low = 1'b0;
      wus(10); mid = line;
      wus(30);
      chk("R6 late tx not driven", int'(mid), 1);
      chk("R6 no handshake", hs_cnt - hs0, 0);
      chk("R6 decoded as write 1", int'(rx_last), 1);
      chk("R6 one rx", rx_cnt - rx0, 1);
      tx_valid = 1'b0;
      wus(45);
    end

    begin : long_w0
      int rx0, r0;
      rx0 = rx_cnt; r0 = rst_cnt;
      write_slot(1'b0, 110);
      chk("R9 long write0 not reset", rst_cnt - r0, 0);
      chk("R9 long write0 bit", int'(rx_last), 0);
      chk("R9 long write0 rx", rx_cnt - rx0, 1);
    end

    begin : abort_read
      int rx0;
      rx0 = rx_cnt;
      tx_valid = 1'b1; tx_bit = 1'b0;
      wus(1);
      master_low = 1'b1;
      wus(15);
      chk("R5 read0 driving", int'(bus_pull_low), 1);
      tx_valid = 1'b0;
      bus_reset_seq(485);
      chk("R7 no rx from aborted read", rx_cnt - rx0, 0);
    end

    begin : after_abort
      int rx0;
      rx0 = rx_cnt;
      write_slot(1'b0, 70);
      chk("R4 write after reset", int'(rx_last), 0);
      chk("R4 write after reset count", rx_cnt - rx0, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule